// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small processor core built around one accumulator. A control part holds the program counter, the instruction register and the address register. A data part holds the accumulator, a data register and an arithmetic/logic unit. The core talks to one word-addressed memory through an address, a write-data word, a read-data word and a write strobe. The memory answers a read in the same cycle it is addressed and commits a write at the clock edge.

Each 16-bit instruction word carries a 4-bit operation code in bits 15:12 and a 12-bit address in bits 11:0. The operations are: load, store, the two moves between the accumulator and the data register, add, subtract, bitwise AND, complement, jump, and jump-if-accumulator-zero. There is also a halt code.

The parameter `OVERLAP` chooses how instructions are scheduled. With `OVERLAP = 0`, a fetch cycle and an execute cycle strictly alternate. With `OVERLAP = 1`, the next word is fetched while the current instruction executes. The program counter, the accumulator and a halt flag are brought out so the core can be observed.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset clears PC, AC, DR, IR, AR and the halt flag. After reset the write strobe is low, and the first fetch reads address 0.
- R2: A fetch reads the word at M(PC), places bits 15:12 in IR and bits 11:0 in AR, and increments PC in the same clock cycle. During a fetch `mem_addr` equals PC.
- R3: With OVERLAP=0, every instruction takes exactly two cycles: one fetch, then one execute. A program of n executed instructions, ending with its halt, raises the halt flag after 2n clock edges.
- R4: Load (code 1) sets AC := M(AR). Store (code 2) drives `mem_addr` = AR and `mem_wdata` = AC, with the strobe high for exactly its one execute cycle. The strobe is never high in any other cycle.
- R5: MOVDA (code 3) sets DR := AC, and MOVAD (code 4) sets AC := DR. These two codes, and the arithmetic/logic codes, ignore the address field.
- R6: ADD (5) sets AC := AC + DR and SUB (6) sets AC := AC - DR, both modulo 2^16. AND (7) sets AC := AC & DR, and NOT (8) sets AC := ~AC.
- R7: BRA (9) loads PC from AR in its execute cycle.
- R8: BZ (10) loads PC from AR only when AC is zero. Otherwise, execution continues at the already incremented PC.
- R9: With OVERLAP=1, instruction i+1 is fetched in the cycle that instruction i executes. A straight run of n instructions without memory operands, ending with its halt, raises the halt flag after n+1 edges.
- R10: With OVERLAP=1, the execute cycle of a load or store owns the memory port, so no fetch happens in that cycle. Each executed load or store adds one cycle.
- R11: With OVERLAP=1, a taken BRA or BZ keeps no instruction from its execute cycle. The next fetch comes from the target, and each taken branch adds one cycle.
- R12: Code 0 (halt) sets the halt flag when it executes. From then on no fetch occurs, PC holds, and the strobe stays low until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W (12) | Word address: PC for a fetch, AR for a load or store |
| mem_wdata | output | WORD_W (16) | Store data (the accumulator) |
| mem_rdata | input | WORD_W (16) | Word read from `mem_addr` in the same cycle |
| mem_we | output | 1 | Write strobe, high in the execute cycle of a store |
| pc_o | output | ADDR_W (12) | Program counter |
| ac_o | output | WORD_W (16) | Accumulator |
| halted | output | 1 | Set once a halt instruction has executed |

## Verification
A fetch is visible on `mem_addr` before the edge that consumes it, and a register result appears one edge after its execute cycle. The halt flag therefore rises exactly on the edge that executes the halt. The bench counts edges from the release of reset until it sees the halt flag. It compares that count with 2n in sequential mode, and with n+1 plus one per executed load, store or taken branch in overlapped mode; n, and the load, store and branch counts, come from an instruction-level model in the bench. In sequential mode the address is sampled at the negative edge before every odd-numbered edge and compared with the model's fetch-address trace. Results in memory and in AC are read only after the halt flag is seen.

// File: rtl/acc_pkg.sv
package acc_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_HALT  = 4'd0,
      OP_LD    = 4'd1,
      OP_ST    = 4'd2,
      OP_MOVDA = 4'd3,
      OP_MOVAD = 4'd4,
      OP_ADD   = 4'd5,
      OP_SUB   = 4'd6,
      OP_AND   = 4'd7,
      OP_NOT   = 4'd8,
      OP_BRA   = 4'd9,
      OP_BZ    = 4'd10
   } opcode_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int W = 16
) (
   input  opcode_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   d,
   output logic [W-1:0]   y
);
   always_comb begin
      case (op)
         OP_ADD:  y = a + d;
         OP_SUB:  y = a - d;
         OP_AND:  y = a & d;
         OP_NOT:  y = ~a;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/acc_dpu.sv
module acc_dpu
   import acc_pkg::*;
#(
   parameter int W = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  opcode_e       op,
   input  logic [W-1:0]  rdata,
   output logic [W-1:0]  ac,
   output logic [W-1:0]  dr
);
   logic [W-1:0] alu_y;

   acc_alu #(.W(W)) u_alu (
      .op (op),
      .a  (ac),
      .d  (dr),
      .y  (alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ac <= '0;
         dr <= '0;
      end else if (en) begin
         case (op)
            OP_LD:                         ac <= rdata;
            OP_MOVDA:                      dr <= ac;
            OP_MOVAD:                      ac <= dr;
            OP_ADD, OP_SUB, OP_AND, OP_NOT: ac <= alu_y;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/acc_pcu.sv
module acc_pcu
   import acc_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int WORD_W  = 16,
   parameter bit OVERLAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] rdata,
   input  logic              ex_mem,
   input  logic              br_take,
   input  logic              ex_halt,
   output logic [ADDR_W-1:0] pc,
   output opcode_e           ir,
   output logic [ADDR_W-1:0] ar,
   output logic              ir_valid,
   output logic              halted
);
   logic hold;
   logic fetch_en;

   generate
      if (OVERLAP == 1'b0) begin : g_seq
         assign hold = ir_valid;
      end else begin : g_ovl
         assign hold = ir_valid & (ex_mem | br_take | ex_halt);
      end
   endgenerate

   assign fetch_en = ~halted & ~hold;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc       <= '0;
         ir       <= OP_HALT;
         ar       <= '0;
         ir_valid <= 1'b0;
         halted   <= 1'b0;
      end else begin
         if (ir_valid && ex_halt) halted <= 1'b1;
         if (fetch_en) begin
            ir       <= opcode_e'(rdata[WORD_W-1 -: OPC_W]);
            ar       <= rdata[ADDR_W-1:0];
            pc       <= pc + 1'b1;
            ir_valid <= 1'b1;
         end else begin
            ir_valid <= 1'b0;
            if (br_take) pc <= ar;
         end
      end
   end
endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int WORD_W  = OPC_W + ADDR_W,
   parameter bit OVERLAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic [ADDR_W-1:0] pc_o,
   output logic [WORD_W-1:0] ac_o,
   output logic              halted
);
   generate
      if (WORD_W != OPC_W + ADDR_W) begin : g_bad_width
         $error("acc_core: WORD_W must equal opcode width plus ADDR_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("acc_core: ADDR_W must be at least 2");
      end
   endgenerate

   opcode_e           ir_op;
   logic [ADDR_W-1:0] ar_q;
   logic [ADDR_W-1:0] pc_q;
   logic              ir_valid;
   logic              halted_q;
   logic [WORD_W-1:0] ac_q;
   logic [WORD_W-1:0] dr_q;
   logic              ex_ldst;
   logic              ac_zero;
   logic              br_take;

   assign ex_ldst = ir_valid && (ir_op == OP_LD || ir_op == OP_ST);
   assign ac_zero = (ac_q == '0);
   assign br_take = ir_valid && (ir_op == OP_BRA || (ir_op == OP_BZ && ac_zero));

   acc_pcu #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OVERLAP(OVERLAP)) u_pcu (
      .clk      (clk),
      .rst      (rst),
      .rdata    (mem_rdata),
      .ex_mem   (ex_ldst),
      .br_take  (br_take),
      .ex_halt  (ir_op == OP_HALT),
      .pc       (pc_q),
      .ir       (ir_op),
      .ar       (ar_q),
      .ir_valid (ir_valid),
      .halted   (halted_q)
   );

   acc_dpu #(.W(WORD_W)) u_dpu (
      .clk   (clk),
      .rst   (rst),
      .en    (ir_valid),
      .op    (ir_op),
      .rdata (mem_rdata),
      .ac    (ac_q),
      .dr    (dr_q)
   );

   assign mem_addr  = ex_ldst ? ar_q : pc_q;
   assign mem_wdata = ac_q;
   assign mem_we    = ir_valid && (ir_op == OP_ST);
   assign pc_o      = pc_q;
   assign ac_o      = ac_q;
   assign halted    = halted_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
   import acc_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int WORD_W  = 16,
   parameter bit OVERLAP = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] pc,
   input logic [WORD_W-1:0] ac,
   input logic              halted,
   input logic              mem_we,
   input logic              ir_valid,
   input logic [OPC_W-1:0]  op,
   input logic [ADDR_W-1:0] ar
);
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (pc == '0 && ac == '0 && !halted && !mem_we)); // R1

   AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we); // R4

   AST_BRA_TARGET: assert property (@(posedge clk) disable iff (rst)
      (ir_valid && op == OP_BRA) |=> pc == $past(ar)); // R7

   AST_BZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (ir_valid && op == OP_BZ && ac == '0) |=> pc == $past(ar)); // R8

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && $stable(pc))); // R12

   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
      halted |-> (!mem_we && !ir_valid)); // R12

   generate
      if (OVERLAP == 1'b0) begin : g_seq
         AST_SEQ_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
            ir_valid |=> !ir_valid); // R3
      end else begin : g_ovl
         AST_OVL_MEM_STALL: assert property (@(posedge clk) disable iff (rst)
            (ir_valid && (op == OP_LD || op == OP_ST)) |=> !ir_valid); // R10

         AST_OVL_BRANCH_FLUSH: assert property (@(posedge clk) disable iff (rst)
            (ir_valid && op == OP_BRA) |=> !ir_valid); // R11
      end
   endgenerate
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OVERLAP(OVERLAP)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pc       (pc_o),
   .ac       (ac_o),
   .halted   (halted),
   .mem_we   (mem_we),
   .ir_valid (ir_valid),
   .op       (ir_op),
   .ar       (ar_q)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [11:0] a0, a1, pc0, pc1;
   logic [15:0] wd0, wd1, rd0, rd1, ac0, ac1;
   logic        we0, we1, h0, h1;

   logic [15:0] mem0 [0:255];
   logic [15:0] mem1 [0:255];
   logic [15:0] refm [0:255];

   assign rd0 = mem0[a0[7:0]];
   assign rd1 = mem1[a1[7:0]];

   always @(posedge clk) begin
      if (we0 === 1'b1) mem0[a0[7:0]] = wd0;
      if (we1 === 1'b1) mem1[a1[7:0]] = wd1;
   end

   acc_core #(.OVERLAP(1'b0)) u_acc_core (
      .clk(clk), .rst(rst), .mem_addr(a0), .mem_wdata(wd0), .mem_rdata(rd0),
      .mem_we(we0), .pc_o(pc0), .ac_o(ac0), .halted(h0));

   acc_core #(.OVERLAP(1'b1)) u_acc_core_ovl (
      .clk(clk), .rst(rst), .mem_addr(a1), .mem_wdata(wd1), .mem_rdata(rd1),
      .mem_we(we1), .pc_o(pc1), .ac_o(ac1), .halted(h1));

   int nchk = 0;
   int nerr = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ins(input int op, input int adr);
      logic [3:0]  o = op[3:0];
      logic [11:0] d = adr[11:0];
      return {o, d};
   endfunction

   task automatic put(input int a, input logic [15:0] w);
      mem0[a] = w;
      mem1[a] = w;
      refm[a] = w;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) put(i, 16'h0000);
   endtask

   // instruction-level model
   int          r_n, r_mem, r_tk, r_st;
   logic [15:0] r_ac;
   int          r_tr [0:1023];

   task automatic ref_run();
      int          pc = 0;
      logic [15:0] acc = 0, drg = 0, w;
      int          op, ad;
      bit          done = 0;
      r_n = 0; r_mem = 0; r_tk = 0; r_st = 0;
      for (int s = 0; s < 1000 && !done; s++) begin
         w  = refm[pc % 256];
         op = int'(w[15:12]);
         ad = int'(w[11:0]);
         r_tr[r_n] = pc;
         r_n++;
         pc = (pc + 1) % 4096;
         case (op)
            0:  done = 1;
            1:  begin acc = refm[ad % 256]; r_mem++; end
            2:  begin refm[ad % 256] = acc; r_mem++; r_st++; end
            3:  drg = acc;
            4:  acc = drg;
            5:  acc = acc + drg;
            6:  acc = acc - drg;
            7:  acc = acc & drg;
            8:  acc = ~acc;
            9:  begin pc = ad; r_tk++; end
            10: if (acc == 16'h0) begin pc = ad; r_tk++; end
            default: ;
         endcase
      end
      r_ac = acc;
   endtask

   int cyc0, cyc1;

   task automatic run_prog(input string tag);
      int c = 0, st0 = 0, st1 = 0, trbad = 0, wq = 0, bad0 = 0, bad1 = 0;
      logic [11:0] p0, p1;
      cyc0 = 0; cyc1 = 0;
      @(negedge clk);
      rst = 1'b0;
      while (c < 4000 && !(cyc0 != 0 && cyc1 != 0)) begin
         if (cyc0 == 0) begin
            if (c % 2 == 0 && c / 2 < r_n && a0 !== 12'(r_tr[c / 2])) trbad++;
            if (we0 === 1'b1) st0++;
         end
         if (cyc1 == 0 && we1 === 1'b1) st1++;
         @(posedge clk);
         @(negedge clk);
         c++;
         if (cyc0 == 0 && h0 === 1'b1) cyc0 = c;
         if (cyc1 == 0 && h1 === 1'b1) cyc1 = c;
      end
      p0 = pc0; p1 = pc1;
      repeat (4) begin
         @(negedge clk);
         if (we0 !== 1'b0 || we1 !== 1'b0) wq++;
      end
      chk(pc0 == p0 && pc1 == p1, "R12", {tag, " pc after halt"}, {pc0, pc1}, {p0, p1});
      chk(wq == 0, "R12", {tag, " strobe after halt"}, wq, 0);
      chk(trbad == 0, "R2", {tag, " fetch address trace"}, trbad, 0);
      chk(cyc0 == 2 * r_n, "R3", {tag, " sequential cycles"}, cyc0, 2 * r_n);
      chk(cyc1 == r_n + 1 + r_mem + r_tk, "R9", {tag, " overlapped cycles"},
          cyc1, r_n + 1 + r_mem + r_tk);
      chk(ac0 == r_ac, "R6", {tag, " seq accumulator"}, ac0, r_ac);
      chk(ac1 == r_ac, "R6", {tag, " ovl accumulator"}, ac1, r_ac);
      for (int i = 0; i < 256; i++) begin
         if (mem0[i] !== refm[i]) bad0++;
         if (mem1[i] !== refm[i]) bad1++;
      end
      chk(bad0 == 0 && bad1 == 0, "R4", {tag, " memory image"}, bad0 + bad1, 0);
      chk(st0 == r_st && st1 == r_st, "R4", {tag, " store strobes"}, st0 + st1, 2 * r_st);
   endtask

   task automatic start();
      rst = 1'b1;
      @(negedge clk);
      clear_mem();
   endtask

   task automatic t_reset();
      start();
      ref_run();
      @(negedge clk);
      chk(pc0 == 0 && pc1 == 0, "R1", "pc in reset", {pc0, pc1}, 0);
      chk(ac0 == 0 && ac1 == 0, "R1", "ac in reset", {ac0, ac1}, 0);
      chk(!h0 && !h1 && !we0 && !we1, "R1", "flags in reset", {h0, h1, we0, we1}, 0);
      chk(a0 == 0 && a1 == 0, "R1", "first fetch address", {a0, a1}, 0);
      run_prog("halt-only");
   endtask

   task automatic t_straight();
      start();
      put(0, ins(8, 12'h0AB));
      put(1, ins(3, 12'h0CD));
      put(2, ins(5, 12'h0EF));
      put(3, ins(4, 12'h012));
      put(4, ins(7, 12'h034));
      put(5, ins(0, 0));
      ref_run();
      run_prog("straight");
      chk(cyc1 == 7, "R9", "straight overlapped cycles", cyc1, 7);
      chk(cyc0 == 12, "R3", "straight sequential cycles", cyc0, 12);
      chk(ac0 == 16'hFFFF && ac1 == 16'hFFFF, "R6", "straight result", ac0, 16'hFFFF);
   endtask

   task automatic t_alu();
      start();
      put(40, 16'h1234); put(41, 16'h00FF); put(42, 16'd5); put(43, 16'd9);
      put(0,  ins(1, 40));  put(1,  ins(3, 12'h777)); put(2,  ins(1, 41));
      put(3,  ins(7, 12'h555)); put(4, ins(2, 50)); put(5, ins(8, 0));
      put(6,  ins(2, 51));  put(7,  ins(1, 42)); put(8,  ins(3, 12'h0FF));
      put(9,  ins(1, 43));  put(10, ins(6, 0));  put(11, ins(2, 52));
      put(12, ins(4, 12'h222)); put(13, ins(5, 0)); put(14, ins(2, 53));
      put(15, ins(1, 42));  put(16, ins(6, 0));  put(17, ins(6, 0));
      put(18, ins(2, 54));  put(19, ins(0, 0));
      ref_run();
      run_prog("alu");
      chk(mem0[50] == 16'h0034 && mem1[50] == 16'h0034, "R6", "and result", mem0[50], 16'h0034);
      chk(mem0[51] == 16'hFFCB && mem1[51] == 16'hFFCB, "R6", "not result", mem0[51], 16'hFFCB);
      chk(mem0[52] == 16'd4 && mem1[52] == 16'd4, "R5", "move with address field", mem0[52], 4);
      chk(mem0[53] == 16'd10 && mem1[53] == 16'd10, "R5", "movad then add", mem0[53], 10);
      chk(mem0[54] == 16'hFFFB && mem1[54] == 16'hFFFB, "R6", "sub wrap", mem0[54], 16'hFFFB);
   endtask

   task automatic t_branch();
      start();
      put(0, ins(9, 4));  put(1, ins(8, 0));  put(2, ins(8, 0));  put(3, ins(0, 0));
      put(4, ins(10, 7)); put(5, ins(8, 0));  put(6, ins(0, 0));
      put(7, ins(8, 0));  put(8, ins(10, 1)); put(9, ins(0, 0));
      ref_run();
      run_prog("branch");
      chk(cyc1 == 8, "R11", "taken branches cost one cycle each", cyc1, 8);
      chk(ac1 == 16'hFFFF, "R11", "wrong path not executed", ac1, 16'hFFFF);
      chk(cyc0 == 10, "R7", "sequential branch program", cyc0, 10);
      chk(ac0 == 16'hFFFF && pc0 == 12'd10, "R8", "bz falls through on nonzero", pc0, 10);
   endtask

   task automatic t_mult();
      start();
      put(40, 16'd1); put(41, 16'd3); put(42, 16'd7); put(43, 16'd0);
      put(0,  ins(1, 41)); put(1,  ins(10, 13)); put(2,  ins(1, 40));
      put(3,  ins(3, 0));  put(4,  ins(1, 41));  put(5,  ins(6, 0));
      put(6,  ins(2, 41)); put(7,  ins(1, 42));  put(8,  ins(3, 0));
      put(9,  ins(1, 43)); put(10, ins(5, 0));   put(11, ins(2, 43));
      put(12, ins(9, 0));  put(13, ins(0, 0));
      ref_run();
      run_prog("multiply");
      chk(mem0[43] == 16'd21 && mem1[43] == 16'd21, "R10", "product 3x7", mem1[43], 21);
      chk(cyc1 == r_n + 1 + r_mem + r_tk, "R10", "memory stalls counted", cyc1,
          r_n + 1 + r_mem + r_tk);
      chk(mem0[41] == 0 && pc0 == 12'd14, "R8", "loop exit on zero", pc0, 14);
   endtask

   initial begin
      #(200000 * 5);
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      t_reset();
      t_straight();
      t_alu();
      t_branch();
      t_mult();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule